// File: doc/BRIEF.md
# Dithered Phase-Accumulator Numerically Controlled Oscillator

This block synthesizes a selectable output frequency from a single clock by adding a tuning word K to an N-bit phase register on every cycle, wrapping modulo 2^N. The average output frequency is K/2^N times the clock rate. Three views of the phase are offered together: a one-cycle pulse on every wrap of the register, the register's top bit as a square wave, and a signed J-bit sine amplitude read from a table indexed by the upper W phase bits.

Because a uniformly stepped phase makes a periodic address sequence, the table output carries deterministic spurs. With dither enabled, a pseudo-random offset smaller than one table step is added on the table-address path only, which breaks that periodicity while leaving the phase register, the pulse and the square wave untouched. The tuning word may change at any time; the new value applies on the next clock with no phase reset.

Top module: `dither_nco`

## Requirements
- R1: While rst_ni is low, pulse_o, square_o and sine_o are all 0 and the phase register is 0.
- R2: On every rising clock edge out of reset the phase register becomes (phase + freq_i) mod 2^ACC_W; square_o always equals bit ACC_W-1 of the phase register.
- R3: pulse_o is 1 for exactly the cycle following an edge at which phase + freq_i reached or exceeded 2^ACC_W, and 0 otherwise.
- R4: With ACC_W = 3 and freq_i = 3 held from reset release, pulse_o is high after edges 3, 6, 8, 11, 14 and 16 (edges counted from 1 after release).
- R5: When freq_i/2^ACC_W reduces to a/b, the pulse pattern repeats every b clocks and holds exactly a pulses per b clocks.
- R6: With dither off, sine_o one edge later equals round((2^(AMP_W-1)-1)·sin(π(2a+1)/2^ADDR_W)) within ±1 LSB, two's complement, where a is the top ADDR_W bits of the phase before that edge.
- R7: With dither on, the table index is a or (a+1) mod 2^ADDR_W, since the offset placed below the index LSB is smaller than one table step.
- R8: Dither has no effect on the phase register, pulse_o or square_o.
- R9: A new freq_i applies from the next edge onward, continuing from the current phase.
- R10: With freq_i = 0 the phase holds, pulse_o stays 0 and square_o is stable.
- R11: The dither offset comes from a maximal-length shift register with a non-zero reset seed, so over a long run with dither on the index is at times advanced by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq_i | input | ACC_W | Tuning word K added each cycle |
| dith_en_i | input | 1 | Enables address dither |
| pulse_o | output | 1 | One-cycle pulse on phase wrap |
| square_o | output | 1 | Phase register top bit |
| sine_o | output | AMP_W | Signed sine amplitude, one cycle latency |

## Verification
The bench builds two instances. A tiny one with a 3-bit phase, a 2-bit table index and a 1-bit dither makes the short wrap sequences of small tuning words fully visible, so the exact pulse positions and the a-pulses-per-b-clocks periodicity can be checked over a few clocks. A 16-bit phase with a 256-entry, 10-bit table and 4-bit dither reaches realistic tuning words near one half, rapid tuning changes, a zero word, and long dithered runs where the index advance shows up.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // Feedback masks for maximal-length shift registers, widths 3..16
  function automatic logic [15:0] lfsr_taps(int width);
    case (width)
      3:       return 16'h0006;
      4:       return 16'h000C;
      5:       return 16'h0014;
      6:       return 16'h0030;
      7:       return 16'h0060;
      8:       return 16'h00B8;
      9:       return 16'h0110;
      10:      return 16'h0240;
      11:      return 16'h0500;
      12:      return 16'h0829;
      13:      return 16'h100D;
      14:      return 16'h2015;
      15:      return 16'h6000;
      default: return 16'hD008;
    endcase
  endfunction

endpackage

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] freq_i,
  output logic [ACC_W-1:0] phase_o,
  output logic             carry_o
);
  logic [ACC_W:0]   sum_w;
  logic [ACC_W-1:0] phase_q;
  logic             carry_q;

  assign sum_w = {1'b0, phase_q} + {1'b0, freq_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      carry_q <= 1'b0;
    end else begin
      phase_q <= sum_w[ACC_W-1:0];
      carry_q <= sum_w[ACC_W];
    end
  end

  assign phase_o = phase_q;
  assign carry_o = carry_q;
endmodule

// File: rtl/dither_gen.sv
module dither_gen #(
  parameter int DITH_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DITH_W-1:0] rnd_o
);
  localparam int LFSR_W = (DITH_W < 3) ? 3 : DITH_W;
  localparam logic [15:0] TAPS = nco_pkg::lfsr_taps(LFSR_W);
  localparam logic [LFSR_W-1:0] SEED = LFSR_W'(1);

  logic [LFSR_W-1:0] lfsr_q;
  logic              fb_w;

  assign fb_w = ^(lfsr_q & TAPS[LFSR_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= SEED;
    else         lfsr_q <= {lfsr_q[LFSR_W-2:0], fb_w};
  end

  assign rnd_o = lfsr_q[DITH_W-1:0];
endmodule

// File: rtl/sine_rom.sv
module sine_rom #(
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [AMP_W-1:0]  amp_o
);
  localparam int DEPTH = 1 << ADDR_W;

  // Fixed-point Q28 Taylor series on a folded angle; entry i sits at bin centre
  function automatic logic [AMP_W-1:0] sine_entry(int idx);
    longint pi_q, x, x2, term, acc, amp, res;
    pi_q = 64'sd843314857;
    x = (pi_q * longint'(2 * idx + 1)) >>> ADDR_W;
    if (x > pi_q) x = x - 2 * pi_q;
    if (x > pi_q / 2)       x = pi_q - x;
    else if (x < -pi_q / 2) x = -pi_q - x;
    x2   = (x * x) >>> 28;
    term = x;
    acc  = x;
    for (int k = 1; k <= 7; k++) begin
      term = -((term * x2) >>> 28) / longint'(2 * k * (2 * k + 1));
      acc  = acc + term;
    end
    amp = (64'sd1 <<< (AMP_W - 1)) - 1;
    res = (acc * amp + (64'sd1 <<< 27)) >>> 28;
    return res[AMP_W-1:0];
  endfunction

  logic [AMP_W-1:0] rom_w [DEPTH];
  logic [AMP_W-1:0] amp_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_tab
    localparam logic [AMP_W-1:0] VAL = sine_entry(i);
    assign rom_w[i] = VAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) amp_q <= '0;
    else         amp_q <= rom_w[addr_i];
  end

  assign amp_o = amp_q;
endmodule

// File: rtl/dither_nco.sv
module dither_nco #(
  parameter int ACC_W  = 16,
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 10,
  parameter int DITH_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] freq_i,
  input  logic             dith_en_i,
  output logic             pulse_o,
  output logic             square_o,
  output logic [AMP_W-1:0] sine_o
);
  localparam int LOW_W = ACC_W - ADDR_W;
  localparam int SHIFT = LOW_W - DITH_W;

  logic [ACC_W-1:0]  phase_w;
  logic [LOW_W-1:0]  offset_w;
  logic              step_up_w;
  logic [ADDR_W-1:0] rom_addr_w;

  phase_accum #(.ACC_W(ACC_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .freq_i  (freq_i),
    .phase_o (phase_w),
    .carry_o (pulse_o)
  );

  if (DITH_W > 0) begin : g_dith
    logic [DITH_W-1:0] rnd_w;
    dither_gen #(.DITH_W(DITH_W)) u_dith (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rnd_o  (rnd_w)
    );
    // offset sits just below the index LSB, always under one table step
    assign offset_w = dith_en_i ? (LOW_W'(rnd_w) << SHIFT) : '0;
  end else begin : g_nodith
    assign offset_w = '0;
  end

  // low phase + offset overflows exactly when offset exceeds the headroom
  assign step_up_w  = offset_w > ~phase_w[LOW_W-1:0];
  assign rom_addr_w = phase_w[ACC_W-1 -: ADDR_W] + ADDR_W'(step_up_w);
  assign square_o   = phase_w[ACC_W-1];

  sine_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (rom_addr_w),
    .amp_o  (sine_o)
  );
endmodule

// File: rtl/dither_nco_chk.sv
module dither_nco_chk #(
  parameter int ACC_W  = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ACC_W-1:0]  freq_i,
  input logic              dith_en_i,
  input logic              pulse_o,
  input logic              square_o,
  input logic [ACC_W-1:0]  phase_i,
  input logic [ADDR_W-1:0] rom_addr_i
);
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (ACC_W - 1);

  logic [ADDR_W-1:0] idx_diff;
  assign idx_diff = rom_addr_i - phase_i[ACC_W-1 -: ADDR_W];

  // R3: a falling top bit only happens on a wrap
  a_r3_fall_needs_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(square_o) |-> pulse_o);

  // R3: with both recent words under one half, wraps cannot be adjacent
  a_r3_no_double: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && freq_i < HALF && $past(freq_i) < HALF) |=> !pulse_o);

  // R10: zero word freezes the phase
  a_r10_zero_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_i == '0) |=> (!pulse_o && $stable(square_o)));

  // R7: dithered index within one step of the phase
  a_r7_index_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_diff <= ADDR_W'(1));

  // R6: no dither, index is exactly the phase top bits
  a_r6_plain_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dith_en_i |-> (idx_diff == '0));

  // R1: outputs quiet while reset held
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!pulse_o && !square_o));
endmodule

bind dither_nco dither_nco_chk #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .freq_i     (freq_i),
  .dith_en_i  (dith_en_i),
  .pulse_o    (pulse_o),
  .square_o   (square_o),
  .phase_i    (phase_w),
  .rom_addr_i (rom_addr_w)
);

// File: tb/dither_nco_test.sv
`timescale 1ns/1ps
module dither_nco_test;
  localparam int MN = 16, MW = 8, MJ = 10, MD = 4;
  localparam int SN = 3,  SW = 2, SJ = 8,  SD = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [MN-1:0] k_m = '0;
  logic de_m = 1'b0;
  logic [SN-1:0] k_s = '0;
  logic de_s = 1'b0;
  logic pulse_m, sq_m, pulse_s, sq_s;
  logic [MJ-1:0] sine_m;
  logic [SJ-1:0] sine_s;

  int checks = 0, fails = 0, hits = 0;
  bit done = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  dither_nco #(.ACC_W(MN), .ADDR_W(MW), .AMP_W(MJ), .DITH_W(MD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .freq_i(k_m), .dith_en_i(de_m),
    .pulse_o(pulse_m), .square_o(sq_m), .sine_o(sine_m));

  dither_nco #(.ACC_W(SN), .ADDR_W(SW), .AMP_W(SJ), .DITH_W(SD)) uut_small (
    .clk_i(clk), .rst_ni(rst_n), .freq_i(k_s), .dith_en_i(de_s),
    .pulse_o(pulse_s), .square_o(sq_s), .sine_o(sine_s));

  // behavioural reference state
  longint r_m, r_s;
  bit p_m, p_s, v_m, v_s, d_m;
  int a_m, a_s;

  always @(posedge clk) begin
    if (!rst_n) begin
      r_m = 0; r_s = 0; p_m = 0; p_s = 0; v_m = 0; v_s = 0; d_m = 0;
    end else begin
      a_m = int'(r_m >> (MN - MW)); d_m = de_m; v_m = 1;
      p_m = (r_m + k_m) >= (64'd1 << MN);
      r_m = (r_m + k_m) % (64'd1 << MN);
      a_s = int'(r_s >> (SN - SW)); v_s = 1;
      p_s = (r_s + k_s) >= (64'd1 << SN);
      r_s = (r_s + k_s) % (64'd1 << SN);
    end
  end

  function automatic int sref(int a, int w, int j);
    real th, x;
    th = 3.14159265358979 * real'(2 * a + 1) / (2.0 ** w);
    x  = real'((1 << (j - 1)) - 1) * $sin(th);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s [%s] got %0d expected %0d", req, tag, got, exp);
    end
  endtask

  task automatic cmp_one(bit gp, bit ep, bit gs, bit es, int gsine,
                         int a, bit dith, bit valid, int w, int j);
    int e0, e1;
    check("R3 pulse", gp, ep);
    check("R2 square", gs, es);
    checks++;
    if (!valid) begin
      if (gsine != 0) begin
        fails++;
        $display("FAIL R1 [%s] sine got %0d expected 0", tag, gsine);
      end
    end else begin
      e0 = sref(a, w, j);
      e1 = sref((a + 1) % (1 << w), w, j);
      if (iabs(gsine - e0) <= 1) begin
      end else if (dith && iabs(gsine - e1) <= 1) begin
        hits++;
      end else begin
        fails++;
        $display("FAIL %s [%s] sine got %0d expected %0d", dith ? "R7" : "R6",
                 tag, gsine, e0);
      end
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_one(pulse_m, p_m, sq_m, bit'(r_m >> (MN - 1)), int'($signed(sine_m)),
              a_m, d_m, v_m, MW, MJ);
      cmp_one(pulse_s, p_s, sq_s, bit'(r_s >> (SN - 1)), int'($signed(sine_s)),
              a_s, 1'b0, v_s, SW, SJ);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int q[$];
    bit pb[8];
    int cnt;
    // R1: reset state
    tag = "R1";
    step(3);
    check("R1 pulse", pulse_m, 0);
    check("R1 square", sq_m, 0);
    check("R1 sine", int'(sine_m), 0);

    // R4: 3-bit phase, word 3
    tag = "R4";
    k_s = 3; k_m = 16'h0123;
    rst_n = 1'b1;
    for (int i = 1; i <= 16; i++) begin
      step(1);
      if (pulse_s) q.push_back(i);
    end
    check("R4 pulse count", q.size(), 6);
    if (q.size() == 6) begin
      check("R4 edge", q[0], 3);  check("R4 edge", q[1], 6);
      check("R4 edge", q[2], 8);  check("R4 edge", q[3], 11);
      check("R4 edge", q[4], 14); check("R4 edge", q[5], 16);
    end

    // R5: word 6 -> 3/4, word 2 -> 1/4
    tag = "R5";
    k_s = 6; cnt = 0;
    for (int i = 0; i < 8; i++) begin
      step(1); pb[i] = pulse_s; cnt += int'(pulse_s);
    end
    check("R5 pulses per 8 (3/4)", cnt, 6);
    for (int i = 0; i < 4; i++) check("R5 period", pb[i], pb[i + 4]);
    k_s = 2; cnt = 0;
    for (int i = 0; i < 8; i++) begin
      step(1); pb[i] = pulse_s; cnt += int'(pulse_s);
    end
    check("R5 pulses per 8 (1/4)", cnt, 2);
    for (int i = 0; i < 4; i++) check("R5 period", pb[i], pb[i + 4]);

    // R2/R6: steady tuning over several table sweeps
    tag = "R2/R6";
    step(600);
    // R3: word just below one half
    tag = "R3";
    k_m = 16'h7FFF; step(300);
    k_m = 16'hC001; step(100);
    // R9: frequent tuning changes, phase continuous
    tag = "R9";
    for (int i = 0; i < 25; i++) begin
      k_m = 16'(i * 2749 + 17); step(7);
    end
    // R10: zero word holds phase
    tag = "R10";
    k_m = '0; step(50);
    // R8/R7: dither on, accumulator and pulses unaffected
    tag = "R8/R7";
    de_m = 1'b1; k_m = 16'h0123; step(1500);
    k_m = 16'h0040; step(800);
    // R11: dither does advance the index at times
    tag = "R11";
    checks++;
    if (hits == 0) begin
      fails++;
      $display("FAIL R11 index advance count got 0 expected >0");
    end
    de_m = 1'b0; step(20);
    finish_run();
  end
endmodule